// File: doc/BRIEF.md
# Bitwise Trace Row Consistency Checker

This block watches the row stream produced by a nibble-serial AND/XOR unit and confirms that the rows obey the rules of the trace. Each operation on two 32-bit words takes eight consecutive active rows. Each row moves four bits of each operand, most significant nibble first. A row carries an operation select, the running partial values of both operands, the four bits of each operand's current nibble, and the running output before and after that nibble.

The checker keeps its own eight-step row position counter. Position 0 marks the opening row of an operation. Rules that link a row to the row before it apply at positions 1 to 7, so no rule crosses from the closing row of one operation into the opening row of the next. On the first broken rule the checker raises an error flag and stores a code for the rule class. Both stay fixed until reset. All arithmetic is unsigned and modulo 2^32. Every row column, including the select and the bit columns, is a full 32-bit word, so a bit column can carry an illegal value.

Top module: `bwrow_checker`

## Requirements
- R1: After a synchronous active-low reset, `err_flag` is 0 and `err_code` is 0.
- R2: On every active row, `row_op` and each of the eight bit columns must be 0 or 1. A violation records code 1.
- R3: On a row at position 0, `row_pa` must equal the sum of `row_abits[i]`·2^i, and `row_pb` must equal the same sum over `row_bbits`. `row_prev` must be 0. A violation records code 2.
- R4: On a row at positions 1 to 7, `row_pa` must equal 16 times the previous active row's `row_pa` plus this row's bit sum of `row_abits`. The same rule applies to `row_pb` with `row_bbits`. A violation records code 3.
- R5: On a row at positions 1 to 7, `row_op` must equal the previous active row's `row_op`, and `row_prev` must equal the previous active row's `row_out`. A violation records code 3.
- R6: On every active row, `row_out` must equal 16·`row_prev` plus the slice result. The slice result is the sum of (a_i·b_i)·2^i when `row_op` is 0, and the sum of (a_i XOR b_i)·2^i when `row_op` is 1. A violation records code 4.
- R7: The row after position 7 is checked as a new operation at position 0. A change of select and a `row_prev` of 0 there are legal.
- R8: Each rise of `row_valid` restarts the position at 0, and the position wraps from 7 to 0. Rows with `row_valid` low are not checked, do not advance the position, and cannot set the flag.
- R9: Once set, `err_flag` stays 1 and `err_code` keeps the first recorded code until reset. When one row breaks several rules, the lowest code is recorded.
- R10: `err_flag` and `err_code` are registered. They change on the clock edge that samples the offending row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| row_valid | input | 1 | Row present this cycle |
| row_op | input | 32 | Operation select column (0 = AND, 1 = XOR) |
| row_pa | input | 32 | Partial value of operand a |
| row_pb | input | 32 | Partial value of operand b |
| row_abits | input | 4x32 | Current nibble bits of a, index 0 least significant |
| row_bbits | input | 4x32 | Current nibble bits of b, index 0 least significant |
| row_prev | input | 32 | Output accumulated before this row |
| row_out | input | 32 | Output accumulated after this row |
| err_flag | output | 1 | Sticky rule-violation flag |
| err_code | output | 3 | First violated rule: 0 none, 1 bit value, 2 opening row, 3 row link, 4 output |

## Verification
The bench targets the boundary between operations. It runs two operations back to back with different selects. A checker that applied link rules across positions 7 and 0 would flag this clean stream. It stops a stream after three rows and inserts idle rows with junk fields. A design that failed to restart the position, or that checked idle rows, would report a false error. The bench also breaks more than one rule in a single row, which exposes a wrong priority as a wrong code. It samples the flag one row before and one row after a broken link to catch an error raised a cycle off. It sends clean and faulty rows after a first error to catch a flag or code that is not held.

// File: rtl/bwrow_pkg.sv
`timescale 1ns/1ps
// bwrow_pkg: shared rule codes for the bitwise trace row checker.
// Assumes: codes are ordered so a lower value has higher priority.
package bwrow_pkg;
    typedef enum logic [2:0] {
        RULE_NONE  = 3'd0,
        RULE_BIT   = 3'd1,
        RULE_FIRST = 3'd2,
        RULE_LINK  = 3'd3,
        RULE_OUT   = 3'd4
    } rule_e;
endpackage

// File: rtl/bwrow_phase.sv
`timescale 1ns/1ps
// bwrow_phase: tracks the row position inside an operation.
// Assumes: a rise of row_valid always begins a new operation; idle rows
// neither advance nor reset the count.
module bwrow_phase #(
    parameter int ROWS = 8,
    parameter int PH_W = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            row_valid,
    output logic [PH_W-1:0] cur_phase,
    output logic            is_first
);
    localparam logic [PH_W-1:0] LAST = PH_W'(ROWS - 1);

    logic            valid_q;
    logic [PH_W-1:0] phase_q;

    // Position of the row present this cycle.
    always_comb begin
        cur_phase = (row_valid && !valid_q) ? '0 : phase_q;
        is_first  = (cur_phase == '0);
    end

    // Advance the position on each active row, wrapping after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            phase_q <= '0;
        end else begin
            valid_q <= row_valid;
            if (row_valid) begin
                phase_q <= (cur_phase == LAST) ? '0 : cur_phase + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bwrow_slice.sv
`timescale 1ns/1ps
// bwrow_slice: evaluates the single-row arithmetic of a trace row.
// Assumes: columns are plain unsigned words; sums wrap modulo 2^DATA_W,
// and AND/XOR are formed arithmetically so that illegal bit values still
// produce a defined expected output.
module bwrow_slice #(
    parameter int DATA_W = 32,
    parameter int NIB    = 4
) (
    input  logic [DATA_W-1:0]          op,
    input  logic [NIB-1:0][DATA_W-1:0] abits,
    input  logic [NIB-1:0][DATA_W-1:0] bbits,
    input  logic [DATA_W-1:0]          prev,
    output logic [DATA_W-1:0]          a_sum,
    output logic [DATA_W-1:0]          b_sum,
    output logic [DATA_W-1:0]          exp_out,
    output logic                       bits_ok
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [NIB-1:0][DATA_W-1:0] and_t;
    logic [NIB-1:0][DATA_W-1:0] xor_t;
    logic [NIB-1:0]             lane_ok;
    logic [DATA_W-1:0]          and_sum;
    logic [DATA_W-1:0]          xor_sum;

    // Per-bit product, arithmetic xor and legality.
    for (genvar g = 0; g < NIB; g++) begin : g_lane
        assign and_t[g]   = abits[g] * bbits[g];
        assign xor_t[g]   = abits[g] + bbits[g] - (and_t[g] << 1);
        assign lane_ok[g] = (abits[g] <= ONE) && (bbits[g] <= ONE);
    end

    // Weighted sums of operands and per-bit results.
    always_comb begin
        a_sum   = '0;
        b_sum   = '0;
        and_sum = '0;
        xor_sum = '0;
        for (int k = 0; k < NIB; k++) begin
            a_sum   = a_sum   + (abits[k] << k);
            b_sum   = b_sum   + (bbits[k] << k);
            and_sum = and_sum + (and_t[k] << k);
            xor_sum = xor_sum + (xor_t[k] << k);
        end
    end

    // Expected output and overall bit legality.
    always_comb begin
        exp_out = (prev << NIB) + and_sum + op * (xor_sum - and_sum);
        bits_ok = (&lane_ok) && (op <= ONE);
    end
endmodule

// File: rtl/bwrow_link.sv
`timescale 1ns/1ps
// bwrow_link: holds the previous active row and checks the row-to-row rules.
// Assumes: the result is only used when the current row is not the opening
// row of an operation, so the held row is always its direct predecessor.
module bwrow_link #(
    parameter int DATA_W = 32,
    parameter int NIB    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_valid,
    input  logic [DATA_W-1:0] op,
    input  logic [DATA_W-1:0] pa,
    input  logic [DATA_W-1:0] pb,
    input  logic [DATA_W-1:0] prev,
    input  logic [DATA_W-1:0] out,
    input  logic [DATA_W-1:0] a_sum,
    input  logic [DATA_W-1:0] b_sum,
    output logic              link_ok
);
    logic [DATA_W-1:0] op_q;
    logic [DATA_W-1:0] pa_q;
    logic [DATA_W-1:0] pb_q;
    logic [DATA_W-1:0] out_q;

    // Capture every active row for comparison with the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            pa_q  <= '0;
            pb_q  <= '0;
            out_q <= '0;
        end else if (row_valid) begin
            op_q  <= op;
            pa_q  <= pa;
            pb_q  <= pb;
            out_q <= out;
        end
    end

    // Compare the current row against the held predecessor.
    always_comb begin
        link_ok = (op == op_q)
               && (pa == (pa_q << NIB) + a_sum)
               && (pb == (pb_q << NIB) + b_sum)
               && (prev == out_q);
    end
endmodule

// File: rtl/bwrow_checker.sv
`timescale 1ns/1ps
// bwrow_checker: streaming rule checker for nibble-serial AND/XOR trace rows.
// Assumes: one row per cycle while row_valid is high; ROWS rows per
// operation; the first violation is latched until reset.
module bwrow_checker #(
    parameter int DATA_W = 32,
    parameter int NIB    = 4,
    parameter int ROWS   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       row_valid,
    input  logic [DATA_W-1:0]          row_op,
    input  logic [DATA_W-1:0]          row_pa,
    input  logic [DATA_W-1:0]          row_pb,
    input  logic [NIB-1:0][DATA_W-1:0] row_abits,
    input  logic [NIB-1:0][DATA_W-1:0] row_bbits,
    input  logic [DATA_W-1:0]          row_prev,
    input  logic [DATA_W-1:0]          row_out,
    output logic                       err_flag,
    output logic [2:0]                 err_code
);
    import bwrow_pkg::*;

    localparam int PH_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic [PH_W-1:0]   cur_phase;
    logic              is_first;
    logic [DATA_W-1:0] a_sum;
    logic [DATA_W-1:0] b_sum;
    logic [DATA_W-1:0] exp_out;
    logic              bits_ok;
    logic              link_ok;
    logic              v_bit, v_first, v_link, v_out;
    rule_e             hit_code;
    rule_e             code_q;
    logic              flag_q;

    bwrow_phase #(.ROWS(ROWS), .PH_W(PH_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_valid (row_valid),
        .cur_phase (cur_phase),
        .is_first  (is_first)
    );

    bwrow_slice #(.DATA_W(DATA_W), .NIB(NIB)) u_slice (
        .op      (row_op),
        .abits   (row_abits),
        .bbits   (row_bbits),
        .prev    (row_prev),
        .a_sum   (a_sum),
        .b_sum   (b_sum),
        .exp_out (exp_out),
        .bits_ok (bits_ok)
    );

    bwrow_link #(.DATA_W(DATA_W), .NIB(NIB)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_valid (row_valid),
        .op        (row_op),
        .pa        (row_pa),
        .pb        (row_pb),
        .prev      (row_prev),
        .out       (row_out),
        .a_sum     (a_sum),
        .b_sum     (b_sum),
        .link_ok   (link_ok)
    );

    // Classify rule violations of the current row.
    always_comb begin
        v_bit   = row_valid && !bits_ok;
        v_first = row_valid && is_first &&
                  !((row_pa == a_sum) && (row_pb == b_sum) && (row_prev == '0));
        v_link  = row_valid && !is_first && !link_ok;
        v_out   = row_valid && (row_out != exp_out);
    end

    // Pick the highest-priority violation of this row.
    always_comb begin
        if (v_bit)        hit_code = RULE_BIT;
        else if (v_first) hit_code = RULE_FIRST;
        else if (v_link)  hit_code = RULE_LINK;
        else if (v_out)   hit_code = RULE_OUT;
        else              hit_code = RULE_NONE;
    end

    // Latch the first violation until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            code_q <= RULE_NONE;
        end else if (!flag_q && hit_code != RULE_NONE) begin
            flag_q <= 1'b1;
            code_q <= hit_code;
        end
    end

    assign err_flag = flag_q;
    assign err_code = code_q;
endmodule

// File: rtl/bwrow_checker_sva.sv
`timescale 1ns/1ps
// bwrow_checker_sva: temporal properties of the row checker, bound to it.
// Assumes: reset is synchronous and active low.
module bwrow_checker_sva #(
    parameter int ROWS = 8,
    parameter int PH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            row_valid,
    input logic            err_flag,
    input logic [2:0]      err_code,
    input logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(ROWS - 1);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);                                           // R9
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> $stable(err_code));                                  // R9
    AST_CODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flag |-> err_code == 3'd0);                                  // R1
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (err_code != 3'd0 && err_code <= 3'd4));             // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_valid && !err_flag) |=> !err_flag);                         // R8
    AST_PHASE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && $past(rst_n) && !$past(row_valid)) |-> phase == '0); // R8
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && $past(rst_n) && $past(row_valid)) |->
        phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1));    // R8
endmodule

bind bwrow_checker bwrow_checker_sva #(.ROWS(ROWS), .PH_W(PH_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_valid (row_valid),
    .err_flag  (err_flag),
    .err_code  (err_code),
    .phase     (cur_phase)
);

// File: tb/bwrow_checker_test.sv
`timescale 1ns/1ps
module bwrow_checker_test;
    logic             clk = 1'b0;
    logic             rst_n;
    logic             row_valid;
    logic [31:0]      row_op, row_pa, row_pb, row_prev, row_out;
    logic [3:0][31:0] row_abits, row_bbits;
    logic             err_flag;
    logic [2:0]       err_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic pre_flag, post_flag;

    always #2.5 clk = ~clk;

    bwrow_checker uut (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid),
        .row_op(row_op), .row_pa(row_pa), .row_pb(row_pb),
        .row_abits(row_abits), .row_bbits(row_bbits),
        .row_prev(row_prev), .row_out(row_out),
        .err_flag(err_flag), .err_code(err_code)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; row_valid = 1'b0;
        row_op = '0; row_pa = '0; row_pb = '0; row_prev = '0; row_out = '0;
        row_abits = '0; row_bbits = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            row_valid = 1'b0;
        end
    endtask

    // idle rows with junk contents
    task automatic junk_rows(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            row_valid = 1'b0;
            row_op = 32'd9; row_pa = 32'hDEAD; row_pb = 32'hBEEF;
            row_prev = 32'd77; row_out = 32'd3;
            for (int i = 0; i < 4; i++) begin
                row_abits[i] = 32'd7; row_bbits[i] = 32'd5;
            end
        end
    endtask

    // kinds: 1 bit=2, 2 pa+1, 3 prev=5, 4 pb+1, 5 op flip, 6 prev+1 (out fixed), 7 out+1
    task automatic op_rows(logic [31:0] a, logic [31:0] b, bit x, int nrows,
                           int bad_row, int kind);
        logic [31:0] res, na, nb, pa, pb, pv, ov, opv;
        logic [3:0][31:0] ab, bb;
        int sh;
        res = x ? (a ^ b) : (a & b);
        for (int r = 0; r < nrows; r++) begin
            sh  = 4 * (7 - r);
            na  = (a >> sh) & 32'hF;
            nb  = (b >> sh) & 32'hF;
            pa  = a >> sh;
            pb  = b >> sh;
            ov  = res >> sh;
            pv  = (r == 0) ? 32'd0 : (res >> (sh + 4));
            opv = {31'd0, x};
            for (int i = 0; i < 4; i++) begin
                ab[i] = {31'd0, na[i]};
                bb[i] = {31'd0, nb[i]};
            end
            if (r == bad_row) begin
                case (kind)
                    1: ab[1] = 32'd2;
                    2: pa = pa + 32'd1;
                    3: pv = 32'd5;
                    4: pb = pb + 32'd1;
                    5: opv = {31'd0, ~x};
                    6: begin pv = pv + 32'd1; ov = ov + 32'd16; end
                    7: ov = ov + 32'd1;
                    default: ;
                endcase
            end
            @(negedge clk);
            if (r == bad_row)     pre_flag  = err_flag;
            if (r == bad_row + 1) post_flag = err_flag;
            row_valid = 1'b1;
            row_op = opv; row_pa = pa; row_pb = pb;
            row_abits = ab; row_bbits = bb;
            row_prev = pv; row_out = ov;
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 flag after reset", {31'd0, err_flag}, 32'd0);
        chk("R1 code after reset", {29'd0, err_code}, 32'd0);
    endtask

    task automatic t_clean_streams();
        do_reset();
        op_rows(32'hF0F0_1234, 32'h0FF0_FEDC, 1'b0, 8, -1, 0);   // AND
        op_rows(32'hA5A5_5A5A, 32'h1234_5678, 1'b1, 8, -1, 0);   // XOR, back to back
        op_rows(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, 8, -1, 0);
        idle(2);
        chk("R6 R4 R7 clean back-to-back flag", {31'd0, err_flag}, 32'd0);
        chk("R7 clean back-to-back code", {29'd0, err_code}, 32'd0);
    endtask

    task automatic t_bit_value();
        do_reset();
        op_rows(32'h1357_9BDF, 32'h2468_ACE0, 1'b1, 8, 3, 1);
        idle(2);
        chk("R2 bit value flag", {31'd0, err_flag}, 32'd1);
        chk("R2 R9 bit value code wins", {29'd0, err_code}, 32'd1);
    endtask

    task automatic t_first_row();
        do_reset();
        op_rows(32'h7777_0001, 32'h0303_0303, 1'b0, 8, 0, 3);
        idle(2);
        chk("R3 R9 nonzero prev on opening row", {29'd0, err_code}, 32'd2);
        do_reset();
        op_rows(32'hC001_D00D, 32'h0000_FFFF, 1'b1, 8, 0, 2);
        idle(2);
        chk("R3 opening pa mismatch", {29'd0, err_code}, 32'd2);
    endtask

    task automatic t_link_timing();
        do_reset();
        op_rows(32'h89AB_CDEF, 32'h0123_4567, 1'b0, 8, 4, 4);
        idle(2);
        chk("R10 flag low before bad row", {31'd0, pre_flag}, 32'd0);
        chk("R10 flag high after bad row", {31'd0, post_flag}, 32'd1);
        chk("R4 pb link code", {29'd0, err_code}, 32'd3);
    endtask

    task automatic t_link_op_prev();
        do_reset();
        op_rows(32'h5555_AAAA, 32'h3333_CCCC, 1'b0, 8, 5, 5);
        idle(2);
        chk("R5 op changed mid operation", {29'd0, err_code}, 32'd3);
        do_reset();
        op_rows(32'h5555_AAAA, 32'h3333_CCCC, 1'b1, 8, 2, 6);
        idle(2);
        chk("R5 prev not equal earlier out", {29'd0, err_code}, 32'd3);
    endtask

    task automatic t_output();
        do_reset();
        op_rows(32'hDEAD_BEEF, 32'hFACE_B00C, 1'b1, 8, 6, 7);
        idle(2);
        chk("R6 output mismatch flag", {31'd0, err_flag}, 32'd1);
        chk("R6 output mismatch code", {29'd0, err_code}, 32'd4);
    endtask

    task automatic t_sticky();
        // continues after t_output without reset
        op_rows(32'h0F0F_0F0F, 32'hFFFF_0000, 1'b0, 8, -1, 0);
        op_rows(32'h0F0F_0F0F, 32'hFFFF_0000, 1'b0, 8, 2, 1);
        idle(3);
        chk("R9 flag held", {31'd0, err_flag}, 32'd1);
        chk("R9 first code held", {29'd0, err_code}, 32'd4);
    endtask

    task automatic t_idle_restart();
        do_reset();
        op_rows(32'h1111_2222, 32'h3333_4444, 1'b1, 3, -1, 0);
        junk_rows(3);
        op_rows(32'h9999_0000, 32'hF00F_F00F, 1'b0, 8, -1, 0);
        junk_rows(2);
        op_rows(32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 8, -1, 0);
        idle(2);
        chk("R8 junk idle rows and restart flag", {31'd0, err_flag}, 32'd0);
        chk("R8 junk idle rows and restart code", {29'd0, err_code}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        row_valid = 1'b0;
        t_reset();
        t_clean_streams();
        t_bit_value();
        t_first_row();
        t_link_timing();
        t_link_op_prev();
        t_output();
        t_sticky();
        t_idle_restart();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule